// File: doc/BRIEF.md
# Ordered Key-Value Set Combiner

This unit reads two ascending key-value streams, A and B, and writes a single ascending result stream. Each operation is launched by a one-cycle start pulse that carries a mode and, for the range modes, a bound key. Three modes combine both sources: merge-all, common-keys-only, and keys of A that are absent from B. Four range modes copy the part of A that lies below, above, at-or-below, or at-or-above the bound. Each source marks its end with a level signal that is raised once its last entry has been accepted.

Results pass through an eight-entry result store, R, which is drained on a valid/ready output. Entries leave R as soon as the consumer accepts them. If the consumer holds back and R fills completely, the unit raises a flush request and stops taking source entries. It resumes only after R has been emptied. A one-cycle done pulse closes each operation.

Top module: `ssm_unit`

## Requirements
- R1: Mode 0 (merge-all) emits every key of A and B once, ascending; a key in both carries the value from A.
- R2: Mode 1 (common) emits only keys present in both sources, with the value from A.
- R3: Mode 2 (difference) emits the keys of A that do not appear in B, with their A values.
- R4: Modes 3 and 4 emit the entries of A whose key is strictly less than (3) or strictly greater than (4) the bound.
- R5: Modes 5 and 6 emit the entries of A whose key is less than or equal to (5) or greater than or equal to (6) the bound, so an entry equal to the bound is included.
- R6: In modes 3 to 6 source B is never consumed: b_ready stays low for the whole operation.
- R7: Output keys are strictly ascending. When both sources always present data, every decision produces an entry, and r_ready is held high, one entry leaves per cycle with no gaps.
- R8: When R holds eight entries, flush_req rises and a_ready and b_ready stay low until R is empty again. The held entries keep their order.
- R9: op_done is a single-cycle pulse. It comes one cycle after the last output handshake and never before both sources have signalled end (A only in modes 3 to 6).

Keys and values are 32 bits. After reset, r_valid, flush_req, op_done, a_ready and b_ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Start pulse; ignored while an operation runs |
| op_mode | input | 3 | Operation code 0..6 (see requirements) |
| op_bound | input | 32 | Bound key for the range modes |
| a_valid | input | 1 | Source A entry present |
| a_ready | output | 1 | Source A entry taken this cycle |
| a_key | input | 32 | Source A key |
| a_val | input | 32 | Source A value |
| a_end | input | 1 | Source A has no further entries |
| b_valid | input | 1 | Source B entry present |
| b_ready | output | 1 | Source B entry taken this cycle |
| b_key | input | 32 | Source B key |
| b_val | input | 32 | Source B value |
| b_end | input | 1 | Source B has no further entries |
| r_valid | output | 1 | Result entry present |
| r_ready | input | 1 | Consumer accepts the result entry |
| r_key | output | 32 | Result key |
| r_val | output | 32 | Result value |
| flush_req | output | 1 | R is full and must be drained before work resumes |
| op_done | output | 1 | One-cycle end-of-operation pulse |

## Verification
Two things can happen to R in the same cycle: an entry is written by the combining logic and an entry is read out to the consumer. These meet in the steady state of a merge when r_ready is held high. The bench judges that case by requiring consecutive output cycles with no gap. The harder case is the flush. The consumer is stalled until R is full, then released. The bench checks that source intake stays frozen while R drains, even though a read is leaving every cycle. It also checks that all twelve entries then arrive in ascending order.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef enum logic [2:0] {
    OP_UNION = 3'd0,
    OP_INTER = 3'd1,
    OP_DIFF  = 3'd2,
    OP_LT    = 3'd3,
    OP_GT    = 3'd4,
    OP_LE    = 3'd5,
    OP_GE    = 3'd6
  } ssm_op_e;

  function automatic logic is_range(input ssm_op_e op);
    return (op == OP_LT) || (op == OP_GT) || (op == OP_LE) || (op == OP_GE);
  endfunction

endpackage

// File: rtl/ssm_bound_cmp.sv
module ssm_bound_cmp
  import ssm_pkg::*;
#(
  parameter int KEY_W = 32
) (
  input  ssm_op_e          op,
  input  logic [KEY_W-1:0] key,
  input  logic [KEY_W-1:0] bound,
  output logic             keep
);

  logic lt, eq;

  assign lt = key < bound;
  assign eq = key == bound;

  always_comb begin
    unique case (op)
      OP_LT:   keep = lt;
      OP_GT:   keep = !lt && !eq;
      OP_LE:   keep = lt || eq;
      OP_GE:   keep = !lt;
      default: keep = 1'b0;
    endcase
  end

endmodule

// File: rtl/ssm_core.sv
module ssm_core
  import ssm_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ssm_op_e          op,
  input  logic [KEY_W-1:0] bound,
  input  logic             go,
  input  logic             a_valid,
  input  logic [KEY_W-1:0] a_key,
  input  logic [VAL_W-1:0] a_val,
  input  logic             a_end,
  input  logic             b_valid,
  input  logic [KEY_W-1:0] b_key,
  input  logic [VAL_W-1:0] b_val,
  input  logic             b_end,
  output logic             a_take,
  output logic             b_take,
  output logic             wr_en,
  output logic [KEY_W-1:0] wr_key,
  output logic [VAL_W-1:0] wr_val,
  output logic             finished
);

  logic range_op, a_gone, b_gone, keep;

  assign range_op = is_range(op);
  assign a_gone   = a_end && !a_valid;
  assign b_gone   = b_end && !b_valid;
  assign finished = range_op ? a_gone : (a_gone && b_gone);

  ssm_bound_cmp #(.KEY_W(KEY_W)) u_cmp (
    .op   (op),
    .key  (a_key),
    .bound(bound),
    .keep (keep)
  );

  always_comb begin
    a_take = 1'b0;
    b_take = 1'b0;
    wr_en  = 1'b0;
    if (go) begin
      if (range_op) begin
        if (a_valid) begin
          a_take = 1'b1;
          wr_en  = keep;
        end
      end else if (a_valid && b_valid) begin
        if (a_key < b_key) begin
          a_take = 1'b1;
          wr_en  = (op == OP_UNION) || (op == OP_DIFF);
        end else if (a_key > b_key) begin
          b_take = 1'b1;
          wr_en  = (op == OP_UNION);
        end else begin
          a_take = 1'b1;
          b_take = 1'b1;
          wr_en  = (op == OP_UNION) || (op == OP_INTER);
        end
      end else if (a_valid && b_gone) begin
        a_take = 1'b1;
        wr_en  = (op == OP_UNION) || (op == OP_DIFF);
      end else if (b_valid && a_gone) begin
        b_take = 1'b1;
        wr_en  = (op == OP_UNION);
      end
    end
  end

  assign wr_key = (b_take && !a_take) ? b_key : a_key;
  assign wr_val = (b_take && !a_take) ? b_val : a_val;

  // R2
  inter_both_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == OP_INTER) |-> (a_take && b_take));

endmodule

// File: rtl/ssm_rbuf.sv
module ssm_rbuf #(
  parameter int KEY_W = 32,
  parameter int VAL_W = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_val,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [KEY_W-1:0] rd_key,
  output logic [VAL_W-1:0] rd_val,
  output logic             room,
  output logic             empty,
  output logic             flush
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = KEY_W + VAL_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count, cnt_nxt;
  logic             flush_q, rd_fire;

  assign rd_valid = count != '0;
  assign empty    = count == '0;
  assign rd_fire  = rd_valid && rd_ready;
  assign room     = !flush_q && (count < FULL);
  assign flush    = flush_q;
  assign rd_key   = mem[rd_ptr][ENT_W-1:VAL_W];
  assign rd_val   = mem[rd_ptr][VAL_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= {wr_key, wr_val};
  end

  always_comb begin
    cnt_nxt = count;
    if (wr_en && !rd_fire)      cnt_nxt = count + 1'b1;
    else if (!wr_en && rd_fire) cnt_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      flush_q <= 1'b0;
    end else begin
      if (wr_en)   wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_fire) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= cnt_nxt;
      if (cnt_nxt == FULL)    flush_q <= 1'b1;
      else if (cnt_nxt == '0) flush_q <= 1'b0;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count < FULL));

  // R8
  flush_at_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flush_q) |-> (count == FULL));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_key) && $stable(rd_val)));

endmodule

// File: rtl/ssm_unit.sv
module ssm_unit
  import ssm_pkg::*;
#(
  parameter int KEY_W   = 32,
  parameter int VAL_W   = 32,
  parameter int R_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_start,
  input  logic [2:0]       op_mode,
  input  logic [KEY_W-1:0] op_bound,
  input  logic             a_valid,
  output logic             a_ready,
  input  logic [KEY_W-1:0] a_key,
  input  logic [VAL_W-1:0] a_val,
  input  logic             a_end,
  input  logic             b_valid,
  output logic             b_ready,
  input  logic [KEY_W-1:0] b_key,
  input  logic [VAL_W-1:0] b_val,
  input  logic             b_end,
  output logic             r_valid,
  input  logic             r_ready,
  output logic [KEY_W-1:0] r_key,
  output logic [VAL_W-1:0] r_val,
  output logic             flush_req,
  output logic             op_done
);

  ssm_op_e          op_q;
  logic [KEY_W-1:0] bound_q;
  logic             busy, done_q;
  logic             room, empty, finished;
  logic             wr_en, a_take, b_take;
  logic [KEY_W-1:0] wr_key;
  logic [VAL_W-1:0] wr_val;

  ssm_core #(.KEY_W(KEY_W), .VAL_W(VAL_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .op      (op_q),
    .bound   (bound_q),
    .go      (busy && room),
    .a_valid (a_valid),
    .a_key   (a_key),
    .a_val   (a_val),
    .a_end   (a_end),
    .b_valid (b_valid),
    .b_key   (b_key),
    .b_val   (b_val),
    .b_end   (b_end),
    .a_take  (a_take),
    .b_take  (b_take),
    .wr_en   (wr_en),
    .wr_key  (wr_key),
    .wr_val  (wr_val),
    .finished(finished)
  );

  ssm_rbuf #(.KEY_W(KEY_W), .VAL_W(VAL_W), .DEPTH(R_DEPTH)) u_rbuf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_key  (wr_key),
    .wr_val  (wr_val),
    .rd_ready(r_ready),
    .rd_valid(r_valid),
    .rd_key  (r_key),
    .rd_val  (r_val),
    .room    (room),
    .empty   (empty),
    .flush   (flush_req)
  );

  assign a_ready = a_take;
  assign b_ready = b_take;
  assign op_done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= OP_UNION;
      bound_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy && op_start) begin
        busy    <= 1'b1;
        op_q    <= ssm_op_e'(op_mode);
        bound_q <= op_bound;
      end else if (busy && finished && empty) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  logic             seen_out;
  logic [KEY_W-1:0] prev_key;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_out <= 1'b0;
      prev_key <= '0;
    end else if (!busy && op_start) begin
      seen_out <= 1'b0;
    end else if (r_valid && r_ready) begin
      seen_out <= 1'b1;
      prev_key <= r_key;
    end
  end

  // R7
  ascending_chk: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_ready && seen_out) |-> (r_key > prev_key));

  // R8
  flush_stall_chk: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (!a_ready && !b_ready));

  // R6
  range_no_b_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && is_range(op_q)) |-> !b_ready);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);

endmodule

// File: tb/tb_ssm_unit.sv
module tb_ssm_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_start = 1'b0;
  logic [2:0]  op_mode = 3'd0;
  logic [31:0] op_bound = '0;
  logic        a_valid, a_ready, a_end, b_valid, b_ready, b_end;
  logic [31:0] a_key, a_val, b_key, b_val, r_key, r_val;
  logic        r_valid, r_ready = 1'b1, flush_req, op_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssm_unit dut (
    .clk(clk), .rst(rst), .op_start(op_start), .op_mode(op_mode), .op_bound(op_bound),
    .a_valid(a_valid), .a_ready(a_ready), .a_key(a_key), .a_val(a_val), .a_end(a_end),
    .b_valid(b_valid), .b_ready(b_ready), .b_key(b_key), .b_val(b_val), .b_end(b_end),
    .r_valid(r_valid), .r_ready(r_ready), .r_key(r_key), .r_val(r_val),
    .flush_req(flush_req), .op_done(op_done)
  );

  logic [31:0] ak [16], av [16], bk [16], bv [16];
  logic [31:0] ek [32], ev [32];
  logic [31:0] ok [32], ov [32];
  int oc [32];
  int an = 0, bn = 0, en = 0;
  int ai = 0, bi = 0, on = 0;
  int cyc = 0, done_cnt = 0, done_cyc = 0;
  logic run = 1'b0, clr = 1'b0, a_end_en = 1'b1, b_end_en = 1'b1;
  int nchk = 0, nfail = 0;

  always_comb begin
    a_valid = run && (ai < an);
    a_key   = (ai < an) ? ak[ai] : '0;
    a_val   = (ai < an) ? av[ai] : '0;
    a_end   = run && (ai >= an) && a_end_en;
    b_valid = run && (bi < bn);
    b_key   = (bi < bn) ? bk[bi] : '0;
    b_val   = (bi < bn) ? bv[bi] : '0;
    b_end   = run && (bi >= bn) && b_end_en;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin
      ai <= 0; bi <= 0; on <= 0; done_cnt <= 0;
    end else begin
      if (a_valid && a_ready) ai <= ai + 1;
      if (b_valid && b_ready) bi <= bi + 1;
      if (r_valid && r_ready && on < 32) begin
        ok[on] <= r_key; ov[on] <= r_val; oc[on] <= cyc; on <= on + 1;
      end
      if (op_done) begin
        done_cnt <= done_cnt + 1; done_cyc <= cyc;
      end
    end
  end

  task automatic chk(input bit cond, input string tag, input longint act, input longint exp);
    nchk++;
    if (!cond) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    an = 0; bn = 0; en = 0;
  endtask
  task automatic pa(input int k, input int v); ak[an] = k; av[an] = v; an++; endtask
  task automatic pb(input int k, input int v); bk[bn] = k; bv[bn] = v; bn++; endtask
  task automatic pe(input int k, input int v); ek[en] = k; ev[en] = v; en++; endtask

  task automatic start_op(input logic [2:0] mode, input logic [31:0] bound);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    op_mode = mode; op_bound = bound; op_start = 1'b1; run = 1'b1;
    @(negedge clk); op_start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (done_cnt == 0 && n < 300) begin
      @(negedge clk); n++;
    end
    chk(done_cnt == 1, {tag, " done seen"}, done_cnt, 1);
    repeat (2) @(negedge clk);
    run = 1'b0;
  endtask

  task automatic cmp_out(input string tag);
    chk(on == en, {tag, " count"}, on, en);
    for (int i = 0; i < en && i < on; i++) begin
      chk(ok[i] == ek[i], {tag, " key"}, ok[i], ek[i]);
      chk(ov[i] == ev[i], {tag, " val"}, ov[i], ev[i]);
    end
  endtask

  task automatic load_ab();
    clear_all();
    pa(2, 102); pa(5, 105); pa(9, 109); pa(12, 112);
    pb(1, 201); pb(5, 205); pb(10, 210); pb(12, 212); pb(20, 220);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!r_valid && !flush_req && !op_done, "reset outputs idle", {r_valid, flush_req, op_done}, 0);
    chk(!a_ready && !b_ready, "reset readies low", {a_ready, b_ready}, 0);
  endtask

  task automatic t_union();  // R1, R7, R9
    load_ab();
    pe(1, 201); pe(2, 102); pe(5, 105); pe(9, 109); pe(10, 210); pe(12, 112); pe(20, 220);
    start_op(3'd0, 0);
    wait_done("R1 union");
    cmp_out("R1 union");
    chk(oc[en-1] - oc[0] == en - 1, "R7 back-to-back output", oc[en-1] - oc[0], en - 1);
    // done registered one edge after last handshake, observed on the following edge
    chk(done_cyc == oc[en-1] + 2, "R9 done follows last output", done_cyc, oc[en-1] + 2);
  endtask

  task automatic t_inter();  // R2
    load_ab(); pe(5, 105); pe(12, 112);
    start_op(3'd1, 0); wait_done("R2 inter"); cmp_out("R2 inter");
  endtask

  task automatic t_diff();  // R3
    load_ab(); pe(2, 102); pe(9, 109);
    start_op(3'd2, 0); wait_done("R3 diff"); cmp_out("R3 diff");
  endtask

  task automatic t_range(input logic [2:0] mode, input string tag);  // R4, R5, R6
    start_op(mode, 9); wait_done(tag); cmp_out(tag);
    chk(bi == 0, "R6 source B untouched", bi, 0);
  endtask

  task automatic t_flush();  // R8
    clear_all();
    for (int i = 0; i < 6; i++) begin
      pa(2*i+1, 100+2*i+1); pb(2*i+2, 200+2*i+2);
    end
    for (int i = 1; i <= 12; i++) pe(i, ((i % 2) != 0) ? 100+i : 200+i);
    r_ready = 1'b0;
    start_op(3'd0, 0);
    repeat (30) @(negedge clk);
    chk(flush_req == 1'b1, "R8 flush raised when full", flush_req, 1);
    chk(ai + bi == 8, "R8 intake frozen at eight", ai + bi, 8);
    chk(!a_ready && !b_ready, "R8 readies low in flush", {a_ready, b_ready}, 0);
    r_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(flush_req == 1'b1 && ai + bi == 8, "R8 flush held while draining", ai + bi, 8);
    wait_done("R8 flush");
    cmp_out("R8 flush");
    chk(flush_req == 1'b0, "R8 flush released", flush_req, 0);
  endtask

  task automatic t_done_wait();  // R9
    clear_all();
    pa(4, 104); pb(6, 206); pb(8, 208);
    pe(4, 104); pe(6, 206); pe(8, 208);
    b_end_en = 1'b0;
    start_op(3'd0, 0);
    repeat (20) @(negedge clk);
    chk(done_cnt == 0, "R9 no done before B end", done_cnt, 0);
    chk(on == 3, "R9 entries out before end", on, 3);
    b_end_en = 1'b1;
    wait_done("R9 done after end");
    cmp_out("R9 done");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_union();
    t_inter();
    t_diff();
    load_ab(); pe(2, 102); pe(5, 105);            t_range(3'd3, "R4 less");
    load_ab(); pe(12, 112);                       t_range(3'd4, "R4 greater");
    load_ab(); pe(2, 102); pe(5, 105); pe(9, 109); t_range(3'd5, "R5 less-equal");
    load_ab(); pe(9, 109); pe(12, 112);           t_range(3'd6, "R5 greater-equal");
    t_flush();
    t_done_wait();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule